// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and the pins of a parallel RGB panel port. On each pixel clock edge it takes one 24-bit RGB pixel together with horizontal sync, vertical sync and data-enable. It permutes the three colour channels and packs the result onto 24 output data lines. The packing is one of several 16, 18 or 24 bit lane layouts, some of which carry padding bits between fields. Each of the three control outputs can be inverted, launched on the falling clock edge, or forced off. The data-enable pin can instead carry a composite sync built from the two sync inputs.

Configuration lives in one control word written over a simple 32-bit register port. Reading any other address returns a fixed identifier. The pixel clock is forwarded to a pin, with optional inversion. A master enable bit gates every output. Each time the enable is switched on, the block spends one output cycle flushing its pipeline before it starts forwarding pixels.

Top module: `rgb_par_out`

## Requirements
- R1: Control bits 15:14 pick the channel order fed to the packer, as (first, second, third) slots: 0 = (R,G,B), 1 = (B,G,R), 2 = (G,R,B), 3 = (B,R,G). The input pixel carries R in bits 23:16, G in 15:8 and B in 7:0.
- R2: Control bits 13:11 pick the lane layout, written from line 23 down to line 0, with a/b/c the first/second/third slots:
  - 1: eight zeros, a5 b6 c5.
  - 2: 000 a5 00 b6 000 c5.
  - 3: 00 a5 000 b6 00 c5 0.
  - 4: six zeros, a6 b6 c6.
  - 5: 00 a6 00 b6 00 c6.
  - 6: a8 b8 c8.
  - 0 and 7: all zeros.
  A 5- or 6-bit field is the top bits of its 8-bit channel, truncated without rounding.
- R3: When control bit 10 is set, the pixel clock pin carries the inverted clock. Otherwise it carries the clock unchanged.
- R4: Control bits 9, 8 and 7 invert hsync, vsync and data-enable respectively.
- R5: Control bits 6, 5 and 4 make hsync, vsync and data-enable change half a clock later, on the falling edge. Otherwise they change on the rising edge.
- R6: Control bits 3, 2 and 1 force hsync, vsync and data-enable respectively to 0. This is applied after any inversion.
- R7: While control bit 0 (enable) is 0, all data lines, the three control outputs and the pixel clock pin are 0.
- R8: The first output cycle after enable goes from 0 to 1 drives all data and control outputs to 0. Pixels are forwarded from the next cycle on.
- R9: A read at byte address 0 returns the control word in bits 16:0, with zeros above. A read at any other address returns 0x00647069. A write to any address other than 0 changes nothing.
- R10: With control bit 16 set, the data-enable pin follows the data-enable input. With it clear, the pin carries composite sync, which is 1 only when both hsync and vsync inputs are 0, and R4 and R6 still apply to it.
- R11: Outputs appear one rising edge after their inputs are captured. A control write captured at one edge governs the outputs produced from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| pix_i | input | 24 | Input pixel, R/G/B from high byte down |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Data enable, active high |
| data_o | output | 24 | Packed output data lines |
| hs_o | output | 1 | Formatted horizontal sync |
| vs_o | output | 1 | Formatted vertical sync |
| de_o | output | 1 | Formatted data enable or composite sync |
| pclk_o | output | 1 | Forwarded pixel clock |

## Verification
A control write and a pixel capture can land on the same rising edge. The bench provokes this by holding a pixel steady while a new layout is written. It then checks that the output produced at that edge still uses the old layout and that the next output uses the new one. The same collision is judged at enable turn-on: the edge that takes the enable write must still give zeros, and the following edge must give the flush zeros instead of the pixel.

// File: rtl/rgb_par_out_pkg.sv
package rgb_par_out_pkg;

    localparam logic [31:0] FMT_ID = 32'h0064_7069;

    // control word, bit 16 down to bit 0
    typedef struct packed {
        logic       de_mode;   // 1: data-enable pin, 0: composite sync
        logic [1:0] order;
        logic [2:0] layout;
        logic       pclk_inv;
        logic       hs_inv;
        logic       vs_inv;
        logic       de_inv;
        logic       hs_fall;
        logic       vs_fall;
        logic       de_fall;
        logic       hs_off;
        logic       vs_off;
        logic       de_off;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rgb_ctrl_regs.sv
module rgb_ctrl_regs
    import rgb_par_out_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output ctrl_t             ctrl_q,
    output logic [31:0]       rdata_o
);
    ctrl_t ctrl_d;
    logic  hit;
    logic  unused_wdata_hi;

    assign hit             = (addr_i == '0);
    assign unused_wdata_hi = ^wdata_i[31:CTRL_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i && hit) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
        rdata_o = hit ? {{(32-CTRL_W){1'b0}}, ctrl_q} : FMT_ID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == '0) |=> (ctrl_q == $past(wdata_i[CTRL_W-1:0])));
    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && addr_i == '0)) |=> $stable(ctrl_q));
endmodule

// File: rtl/rgb_lane_pack.sv
module rgb_lane_pack #(
    parameter int CH_W = 8
) (
    input  logic [1:0]        order_i,
    input  logic [2:0]        layout_i,
    input  logic [3*CH_W-1:0] pix_i,
    output logic [3*CH_W-1:0] lanes_o
);
    localparam int OUT_W = 3 * CH_W;

    logic [CH_W-1:0] r, g, b, sa, sb, sc;

    assign r = pix_i[OUT_W-1 -: CH_W];
    assign g = pix_i[2*CH_W-1 -: CH_W];
    assign b = pix_i[CH_W-1:0];

    always_comb begin
        unique case (order_i)
            2'd1:    begin sa = b; sb = g; sc = r; end
            2'd2:    begin sa = g; sb = r; sc = b; end
            2'd3:    begin sa = b; sb = r; sc = g; end
            default: begin sa = r; sb = g; sc = b; end
        endcase
    end

    always_comb begin
        unique case (layout_i)
            3'd1: lanes_o = {{(OUT_W-16){1'b0}}, sa[CH_W-1 -: 5], sb[CH_W-1 -: 6], sc[CH_W-1 -: 5]};
            3'd2: lanes_o = {{(CH_W-5){1'b0}}, sa[CH_W-1 -: 5],
                             {(CH_W-6){1'b0}}, sb[CH_W-1 -: 6],
                             {(CH_W-5){1'b0}}, sc[CH_W-1 -: 5]};
            3'd3: lanes_o = {{(CH_W-6){1'b0}}, sa[CH_W-1 -: 5], 1'b0,
                             {(CH_W-6){1'b0}}, sb[CH_W-1 -: 6],
                             {(CH_W-6){1'b0}}, sc[CH_W-1 -: 5], 1'b0};
            3'd4: lanes_o = {{(OUT_W-18){1'b0}}, sa[CH_W-1 -: 6], sb[CH_W-1 -: 6], sc[CH_W-1 -: 6]};
            3'd5: lanes_o = {{(CH_W-6){1'b0}}, sa[CH_W-1 -: 6],
                             {(CH_W-6){1'b0}}, sb[CH_W-1 -: 6],
                             {(CH_W-6){1'b0}}, sc[CH_W-1 -: 6]};
            3'd6: lanes_o = {sa, sb, sc};
            default: lanes_o = '0;
        endcase
    end
endmodule

// File: rtl/rgb_edge_launch.sv
module rgb_edge_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic d_i,
    output logic q_o
);
    logic fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= d_i;
    end

    assign q_o = fall_i ? fall_q : d_i;

    // R5
    fall_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |-> (q_o == d_i));
endmodule

// File: rtl/rgb_par_out.sv
module rgb_par_out
    import rgb_par_out_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [3*CH_W-1:0] pix_i,
    input  logic              hs_i,
    input  logic              vs_i,
    input  logic              de_i,
    output logic [3*CH_W-1:0] data_o,
    output logic              hs_o,
    output logic              vs_o,
    output logic              de_o,
    output logic              pclk_o
);
    localparam int OUT_W = 3 * CH_W;
    localparam int N_CTL = 3;

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic [N_CTL-1:0] ctl;   // {hs, vs, de}
        logic             en_prev;
    } out_t;

    ctrl_t            ctrl_q;
    out_t             out_d, out_q;
    logic [OUT_W-1:0] lanes;
    logic [N_CTL-1:0] fall_sel, ctl_pins;
    logic             de_src;

    rgb_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .ctrl_q(ctrl_q), .rdata_o(reg_rdata_o)
    );

    rgb_lane_pack #(.CH_W(CH_W)) u_pack (
        .order_i(ctrl_q.order), .layout_i(ctrl_q.layout),
        .pix_i(pix_i), .lanes_o(lanes)
    );

    always_comb begin
        de_src            = ctrl_q.de_mode ? de_i : (~hs_i & ~vs_i);
        out_d.en_prev     = ctrl_q.en;
        out_d.data        = lanes;
        out_d.ctl[2]      = (hs_i   ^ ctrl_q.hs_inv) & ~ctrl_q.hs_off;
        out_d.ctl[1]      = (vs_i   ^ ctrl_q.vs_inv) & ~ctrl_q.vs_off;
        out_d.ctl[0]      = (de_src ^ ctrl_q.de_inv) & ~ctrl_q.de_off;
        if (!ctrl_q.en || !out_q.en_prev) begin
            out_d.data = '0;
            out_d.ctl  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fall_sel = {ctrl_q.hs_fall, ctrl_q.vs_fall, ctrl_q.de_fall};

    for (genvar i = 0; i < N_CTL; i++) begin : g_launch
        rgb_edge_launch u_launch (
            .clk(clk), .rst_n(rst_n), .fall_i(fall_sel[i]),
            .d_i(out_q.ctl[i]), .q_o(ctl_pins[i])
        );
    end

    assign data_o = out_q.data;
    assign hs_o   = ctl_pins[2];
    assign vs_o   = ctl_pins[1];
    assign de_o   = ctl_pins[0];
    assign pclk_o = ctrl_q.en & (clk ^ ctrl_q.pclk_inv);

    // R7
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> (data_o == '0 && hs_o == 1'b0 && vs_o == 1'b0 && de_o == 1'b0));
    // R8
    turn_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.en) |=> (data_o == '0 && out_q.ctl == '0));
    // R2
    full_depth_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && out_q.en_prev && ctrl_q.layout == 3'd6 && ctrl_q.order == 2'd0)
        |=> (data_o == $past(pix_i)));
    // R6
    hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.hs_off |=> (hs_o == 1'b0));
endmodule

// File: tb/rgb_par_out_tb.sv
module rgb_par_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [23:0] pix_i = '0;
    logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
    logic [23:0] data_o;
    logic        hs_o, vs_o, de_o, pclk_o;

    int n_run = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rgb_par_out u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pix_i(pix_i),
        .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i), .data_o(data_o),
        .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .pclk_o(pclk_o)
    );

    // {ctrl, pixel, hs/vs/de in, expected data, expected hs/vs/de}
    localparam int NV = 19;
    localparam logic [70:0] VEC [NV] = '{
        {17'h13001, 24'hF8540C, 3'b101, 24'hF8540C, 3'b101},
        {17'h10801, 24'hF8540C, 3'b101, 24'h00FAA1, 3'b101},
        {17'h11001, 24'hF8540C, 3'b101, 24'h1F1501, 3'b101},
        {17'h11801, 24'hF8540C, 3'b101, 24'h3E1502, 3'b101},
        {17'h12001, 24'hF8540C, 3'b101, 24'h03E543, 3'b101},
        {17'h12801, 24'hF8540C, 3'b101, 24'h3E1503, 3'b101},
        {17'h10001, 24'hF8540C, 3'b101, 24'h000000, 3'b101},
        {17'h13801, 24'hF8540C, 3'b101, 24'h000000, 3'b101},
        {17'h17001, 24'hF8540C, 3'b101, 24'h0C54F8, 3'b101},
        {17'h1B001, 24'hF8540C, 3'b101, 24'h54F80C, 3'b101},
        {17'h1F001, 24'hF8540C, 3'b101, 24'h0CF854, 3'b101},
        {17'h14801, 24'hF8540C, 3'b101, 24'h000ABF, 3'b101},
        {17'h13201, 24'hF8540C, 3'b101, 24'hF8540C, 3'b001},
        {17'h13105, 24'hF8540C, 3'b101, 24'hF8540C, 3'b101},
        {17'h1300B, 24'hF8540C, 3'b111, 24'hF8540C, 3'b010},
        {17'h03001, 24'hF8540C, 3'b000, 24'hF8540C, 3'b001},
        {17'h03001, 24'hF8540C, 3'b010, 24'hF8540C, 3'b010},
        {17'h03081, 24'hF8540C, 3'b010, 24'hF8540C, 3'b011},
        {17'h13081, 24'hF8540C, 3'b001, 24'hF8540C, 3'b000}
    };

    function automatic string row_req(int i);
        if (i < 8)   return "R2";
        if (i < 12)  return "R1";
        if (i == 12) return "R4";
        if (i < 15)  return "R6";
        if (i < 18)  return "R10";
        return "R4";
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] v);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
        @(posedge clk);
        #1 reg_wr_i = 1'b0; reg_addr_i = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #7;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R7 reset state
        chk("R7", "reset data", {8'h0, data_o}, 32'h0);
        chk("R7", "reset ctl", {29'h0, hs_o, vs_o, de_o}, 32'h0);
        chk("R7", "reset pclk", {31'h0, pclk_o}, 32'h0);
        // R9 read map
        reg_addr_i = 8'h00; #1 chk("R9", "ctrl read after reset", reg_rdata_o, 32'h0);
        reg_addr_i = 8'h04; #1 chk("R9", "id read 0x04", reg_rdata_o, 32'h0064_7069);
        reg_addr_i = 8'h10; #1 chk("R9", "id read 0x10", reg_rdata_o, 32'h0064_7069);
        wr_reg(8'h04, 32'h0001_3001);
        reg_addr_i = 8'h00; #1 chk("R9", "write elsewhere ignored", reg_rdata_o, 32'h0);

        // R7 disabled: configured but enable clear
        wr_reg(8'h00, 32'h0001_3000);
        pix_i = 24'hF8540C; {hs_i, vs_i, de_i} = 3'b111;
        step();
        chk("R7", "disabled data", {8'h0, data_o}, 32'h0);
        chk("R7", "disabled ctl", {29'h0, hs_o, vs_o, de_o}, 32'h0);
        chk("R7", "disabled pclk", {31'h0, pclk_o}, 32'h0);

        // R8 turn-on flush, R11 write/capture on same edge
        wr_reg(8'h00, 32'h0001_3001);
        #6 chk("R11", "edge taking enable write", {8'h0, data_o}, 32'h0);
        step();
        chk("R8", "flush data", {8'h0, data_o}, 32'h0);
        chk("R8", "flush ctl", {29'h0, hs_o, vs_o, de_o}, 32'h0);
        step();
        chk("R8", "after flush data", {8'h0, data_o}, 32'h00F8540C);
        chk("R8", "after flush ctl", {29'h0, hs_o, vs_o, de_o}, 32'h7);
        reg_addr_i = 8'h00; #1 chk("R9", "ctrl readback", reg_rdata_o, 32'h0001_3001);

        // vector table: R1 R2 R4 R6 R10
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'h00, {15'h0, VEC[i][70:54]});
            pix_i = VEC[i][53:30];
            {hs_i, vs_i, de_i} = VEC[i][29:27];
            step();
            chk(row_req(i), $sformatf("row %0d data", i), {8'h0, data_o}, {8'h0, VEC[i][26:3]});
            chk(row_req(i), $sformatf("row %0d ctl", i), {29'h0, hs_o, vs_o, de_o}, {29'h0, VEC[i][2:0]});
        end

        // R11 layout change lands one edge after the write
        wr_reg(8'h00, 32'h0001_3001);
        pix_i = 24'hF8540C; {hs_i, vs_i, de_i} = 3'b101;
        step();
        wr_reg(8'h00, 32'h0001_0801);
        #6 chk("R11", "old layout at write edge", {8'h0, data_o}, 32'h00F8540C);
        step();
        chk("R11", "new layout next edge", {8'h0, data_o}, 32'h0000FAA1);

        // R5 falling-edge launch versus rising-edge launch
        wr_reg(8'h00, 32'h0001_3071);
        {hs_i, vs_i, de_i} = 3'b000;
        step();
        chk("R5", "fall mode low", {29'h0, hs_o, vs_o, de_o}, 32'h0);
        {hs_i, vs_i, de_i} = 3'b111;
        @(posedge clk); #2;
        chk("R5", "fall mode before negedge", {29'h0, hs_o, vs_o, de_o}, 32'h0);
        #5 chk("R5", "fall mode after negedge", {29'h0, hs_o, vs_o, de_o}, 32'h7);
        wr_reg(8'h00, 32'h0001_3001);
        {hs_i, vs_i, de_i} = 3'b000;
        step();
        {hs_i, vs_i, de_i} = 3'b111;
        @(posedge clk); #2;
        chk("R5", "rise mode before negedge", {29'h0, hs_o, vs_o, de_o}, 32'h7);

        // R3 clock pin polarity
        #5;
        wr_reg(8'h00, 32'h0001_3401);
        #1 chk("R3", "inverted pclk, clk high", {31'h0, pclk_o}, 32'h0);
        #5 chk("R3", "inverted pclk, clk low", {31'h0, pclk_o}, 32'h1);
        wr_reg(8'h00, 32'h0001_3001);
        #1 chk("R3", "plain pclk, clk high", {31'h0, pclk_o}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule